// File: doc/BRIEF.md
# Trace-History Clear Permission Checker

This block judges a privileged instruction that wipes the processor's record of recent control transfers (jumps, taken branches, traps and trap returns). The pipeline offers it an instruction word with a valid strobe, together with the current privilege mode and four configuration bits. Two bits say whether the machine-level and supervisor-level views of the history feature are built into the core. The other two are the feature's enable bit in the machine state-enable register and its enable bit in the hypervisor state-enable register. The block recognises the one encoding that names the clear instruction. It then returns a registered verdict: perform the clear, raise an illegal-instruction exception, or raise a virtual-instruction exception.

The checks are layered. A missing machine-level implementation rejects the instruction everywhere. User mode and reserved mode codes are always rejected. Below machine mode, the supervisor implementation and the machine enable must both be present. Only after those pass do the guest-mode rules decide whether a virtual-instruction exception applies. The clear itself and the delivery of any trap belong to other blocks.

Top module: `rcc_top`

## Requirements
- R1: Only the exact 32-bit word 0x10400073 is recognised. A strobe with any other word, or a matching word without a strobe, produces no response strobe.
- R2: A strobed matching word gives `rsp_valid` high for exactly one cycle, on the clock edge that samples the request. `rsp_code` then carries a one-hot verdict: bit 0 means perform the clear, bit 1 means illegal instruction, bit 2 means virtual instruction.
- R3: When `cfg_m_impl` is 0, the verdict is illegal instruction in every mode and for every enable setting.
- R4: Mode codes on `req_mode` are 3'b011 machine, 3'b001 supervisor, 3'b000 user, 3'b101 guest supervisor and 3'b100 guest user. All other codes are reserved. User mode and the reserved codes always give illegal instruction.
- R5: In supervisor, guest supervisor or guest user mode, the verdict is illegal instruction when `cfg_s_impl` is 0 or `men_ctr` is 0. This takes priority over any virtual-instruction condition.
- R6: In guest supervisor mode with the R5 conditions met, the verdict is virtual instruction when `hen_ctr` is 0 and perform the clear when it is 1.
- R7: In guest user mode with the R5 conditions met, the verdict is virtual instruction whatever the value of `hen_ctr`.
- R8: In machine mode, with `cfg_m_impl` at 1, the verdict is perform the clear, whatever the values of `cfg_s_impl`, `men_ctr` and `hen_ctr`.
- R9: In supervisor mode with the R5 conditions met, the verdict is perform the clear, whatever the value of `hen_ctr`.
- R10: While reset is held, `rsp_valid` and `rsp_code` read 0. Between strobes, `rsp_code` keeps the last verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe for the instruction word |
| req_insn | input | 32 | Instruction word to judge |
| req_mode | input | 3 | Current privilege mode code (see R4) |
| cfg_m_impl | input | 1 | Machine-level history support is built in |
| cfg_s_impl | input | 1 | Supervisor-level history support is built in |
| men_ctr | input | 1 | Machine state-enable bit for the feature |
| hen_ctr | input | 1 | Hypervisor state-enable bit for the feature |
| rsp_valid | output | 1 | Verdict strobe, one cycle per accepted request |
| rsp_code | output | 3 | One-hot verdict (see R2) |

## Verification
Every verdict and its strobe is due on the first rising edge after the request is driven. There is a single register between the request and the outputs, so the bench drives on a falling edge and samples on the next falling edge. The bench sweeps all eight mode codes against all sixteen configuration settings. It also flips each bit of the matching word, and checks both the missing strobe and the held verdict one cycle later. Reset state is sampled while reset is held, and requests start only after the internal release has had time to pass through.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

  localparam int unsigned RCC_INSN_W = 32;
  localparam int unsigned RCC_MODE_W = 3;
  localparam int unsigned RCC_CODE_W = 3;

  localparam logic [RCC_INSN_W-1:0] RCC_CLEAR_WORD = 32'h1040_0073;

  // privilege mode codes: bit 2 = guest, bits 1:0 = level
  localparam logic [RCC_MODE_W-1:0] MODE_U  = 3'b000;
  localparam logic [RCC_MODE_W-1:0] MODE_S  = 3'b001;
  localparam logic [RCC_MODE_W-1:0] MODE_M  = 3'b011;
  localparam logic [RCC_MODE_W-1:0] MODE_VU = 3'b100;
  localparam logic [RCC_MODE_W-1:0] MODE_VS = 3'b101;

  typedef enum logic [RCC_CODE_W-1:0] {
    RES_NONE = 3'b000,
    RES_EXEC = 3'b001,
    RES_ILL  = 3'b010,
    RES_VIRT = 3'b100
  } rcc_res_e;

endpackage

// File: rtl/rcc_rst_sync.sv
module rcc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];

endmodule

// File: rtl/rcc_decode.sv
module rcc_decode #(
  parameter int unsigned              INSN_W = 32,
  parameter logic [INSN_W-1:0]        MATCH  = 32'h1040_0073
) (
  input  logic              valid,
  input  logic [INSN_W-1:0] insn,
  output logic              hit
);

  logic word_eq;

  always_comb begin
    word_eq = (insn == MATCH);
    hit     = valid & word_eq;
  end

endmodule

// File: rtl/rcc_perm.sv
module rcc_perm
  import rcc_pkg::*;
(
  input  logic [RCC_MODE_W-1:0] mode,
  input  logic                  m_impl,
  input  logic                  s_impl,
  input  logic                  men,
  input  logic                  hen,
  output rcc_res_e              verdict
);

  logic below_m_ok;

  always_comb begin
    below_m_ok = s_impl & men;
    verdict    = RES_ILL;
    if (m_impl) begin
      case (mode)
        MODE_M:  verdict = RES_EXEC;
        MODE_S:  verdict = below_m_ok ? RES_EXEC : RES_ILL;
        MODE_VS: begin
          if (!below_m_ok) verdict = RES_ILL;
          else if (!hen)   verdict = RES_VIRT;
          else             verdict = RES_EXEC;
        end
        MODE_VU: verdict = below_m_ok ? RES_VIRT : RES_ILL;
        default: verdict = RES_ILL;
      endcase
    end
  end

endmodule

// File: rtl/rcc_result_reg.sv
module rcc_result_reg
  import rcc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  rcc_res_e              verdict,
  output logic                  out_valid,
  output logic [RCC_CODE_W-1:0] out_code
);

  logic                  valid_d;
  logic [RCC_CODE_W-1:0] code_d;
  logic                  code_en;

  always_comb begin
    valid_d = load;
    code_en = load;
    code_d  = verdict;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       out_code <= '0;
    else if (code_en) out_code <= code_d;
  end

endmodule

// File: rtl/rcc_top.sv
module rcc_top
  import rcc_pkg::*;
#(
  parameter int unsigned          SYNC_STAGES = 2,
  parameter logic [RCC_INSN_W-1:0] CLEAR_WORD = RCC_CLEAR_WORD
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [RCC_INSN_W-1:0] req_insn,
  input  logic [RCC_MODE_W-1:0] req_mode,
  input  logic                  cfg_m_impl,
  input  logic                  cfg_s_impl,
  input  logic                  men_ctr,
  input  logic                  hen_ctr,
  output logic                  rsp_valid,
  output logic [RCC_CODE_W-1:0] rsp_code
);

  logic     rst_q_n;
  logic     hit;
  rcc_res_e verdict;

  rcc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  rcc_decode #(.INSN_W(RCC_INSN_W), .MATCH(CLEAR_WORD)) u_dec (
    .valid (req_valid),
    .insn  (req_insn),
    .hit   (hit)
  );

  rcc_perm u_perm (
    .mode    (req_mode),
    .m_impl  (cfg_m_impl),
    .s_impl  (cfg_s_impl),
    .men     (men_ctr),
    .hen     (hen_ctr),
    .verdict (verdict)
  );

  rcc_result_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .load      (hit),
    .verdict   (verdict),
    .out_valid (rsp_valid),
    .out_code  (rsp_code)
  );

endmodule

// File: rtl/rcc_checker.sv
module rcc_checker
  import rcc_pkg::*;
#(
  parameter logic [RCC_INSN_W-1:0] CLEAR_WORD = RCC_CLEAR_WORD
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic [RCC_INSN_W-1:0] req_insn,
  input logic [RCC_MODE_W-1:0] req_mode,
  input logic                  cfg_m_impl,
  input logic                  cfg_s_impl,
  input logic                  men_ctr,
  input logic                  hen_ctr,
  input logic                  rsp_valid,
  input logic [RCC_CODE_W-1:0] rsp_code
);

  logic req_hit;
  assign req_hit = req_valid && (req_insn == CLEAR_WORD);

  p_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_hit |=> !rsp_valid);

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_hit |=> (rsp_valid && $countones(rsp_code) == 1));

  p_no_m_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_hit && !cfg_m_impl) |=> (rsp_code == RES_ILL));

  p_user_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_hit && req_mode == MODE_U) |=> (rsp_code == RES_ILL));

  p_lower_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_hit && req_mode != MODE_M && !(cfg_s_impl && men_ctr)) |=> (rsp_code == RES_ILL));

  p_guest_sup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_hit && cfg_m_impl && cfg_s_impl && men_ctr && req_mode == MODE_VS && !hen_ctr)
      |=> (rsp_code == RES_VIRT));

  p_guest_user_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_hit && cfg_m_impl && cfg_s_impl && men_ctr && req_mode == MODE_VU)
      |=> (rsp_code == RES_VIRT));

  p_machine_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_hit && cfg_m_impl && req_mode == MODE_M) |=> (rsp_code == RES_EXEC));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_hit |=> $stable(rsp_code));

endmodule

bind rcc_top rcc_checker #(.CLEAR_WORD(CLEAR_WORD)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .req_valid  (req_valid),
  .req_insn   (req_insn),
  .req_mode   (req_mode),
  .cfg_m_impl (cfg_m_impl),
  .cfg_s_impl (cfg_s_impl),
  .men_ctr    (men_ctr),
  .hen_ctr    (hen_ctr),
  .rsp_valid  (rsp_valid),
  .rsp_code   (rsp_code)
);

// File: tb/sim_rcc_top.sv
module sim_rcc_top;

  localparam int unsigned CLK_PERIOD = 10;
  localparam logic [31:0] WORD = 32'h1040_0073;
  localparam logic [2:0] EX = 3'b001, IL = 3'b010, VI = 3'b100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_insn;
  logic [2:0]  req_mode;
  logic        cfg_m_impl, cfg_s_impl, men_ctr, hen_ctr;
  logic        rsp_valid;
  logic [2:0]  rsp_code;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rcc_top u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_insn(req_insn),
    .req_mode(req_mode), .cfg_m_impl(cfg_m_impl), .cfg_s_impl(cfg_s_impl),
    .men_ctr(men_ctr), .hen_ctr(hen_ctr), .rsp_valid(rsp_valid), .rsp_code(rsp_code)
  );

  task automatic check(input bit ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [2:0] m, input logic mi, input logic si,
                       input logic me, input logic he,
                       output logic [2:0] c, output string t);
    if (!mi) begin c = IL; t = "R3"; end
    else if (m == 3'b011) begin c = EX; t = "R8"; end
    else if (m != 3'b001 && m != 3'b101 && m != 3'b100) begin c = IL; t = "R4"; end
    else if (!si || !me) begin c = IL; t = "R5"; end
    else if (m == 3'b100) begin c = VI; t = "R7"; end
    else if (m == 3'b101) begin c = he ? EX : VI; t = "R6"; end
    else begin c = EX; t = "R9"; end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    logic [2:0] exp_c;
    logic [2:0] last_c;
    string      tag;
    rst_n = 1'b0; req_valid = 1'b0; req_insn = '0; req_mode = '0;
    cfg_m_impl = 1'b0; cfg_s_impl = 1'b0; men_ctr = 1'b0; hen_ctr = 1'b0;
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R10 reset valid", {3'b0, rsp_valid}, 4'h0);
    check(rsp_code == 3'b000, "R10 reset code", {1'b0, rsp_code}, 4'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // exhaustive sweep: 8 mode codes x 16 configurations
    for (int m = 0; m < 8; m++) begin
      for (int cfg = 0; cfg < 16; cfg++) begin
        req_valid = 1'b1; req_insn = WORD; req_mode = 3'(m);
        {cfg_m_impl, cfg_s_impl, men_ctr, hen_ctr} = 4'(cfg);
        model(3'(m), cfg[3], cfg[2], cfg[1], cfg[0], exp_c, tag);
        @(negedge clk);
        check(rsp_valid == 1'b1, "R2 strobe", {3'b0, rsp_valid}, 4'h1);
        check(rsp_code == exp_c, tag, {1'b0, rsp_code}, {1'b0, exp_c});
      end
    end

    // R1: single-bit corruptions of the word, valid high
    last_c = rsp_code;
    for (int b = 0; b < 32; b++) begin
      req_valid = 1'b1; req_insn = WORD ^ (32'h1 << b);
      req_mode = 3'b100; {cfg_m_impl, cfg_s_impl, men_ctr, hen_ctr} = 4'b1110;
      @(negedge clk);
      check(rsp_valid == 1'b0, "R1 no strobe", {3'b0, rsp_valid}, 4'h0);
      check(rsp_code == last_c, "R10 hold", {1'b0, rsp_code}, {1'b0, last_c});
    end

    // R1: matching word without strobe
    req_valid = 1'b0; req_insn = WORD;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1 no valid", {3'b0, rsp_valid}, 4'h0);
    check(rsp_code == last_c, "R10 hold idle", {1'b0, rsp_code}, {1'b0, last_c});

    // R2: strobe lasts one cycle
    req_valid = 1'b1; req_mode = 3'b011; {cfg_m_impl, cfg_s_impl, men_ctr, hen_ctr} = 4'b1000;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_code == EX, "R8 m-mode bare", {1'b0, rsp_code}, {1'b0, EX});
    @(negedge clk);
    check(rsp_valid == 1'b0, "R2 single pulse", {3'b0, rsp_valid}, 4'h0);
    check(rsp_code == EX, "R10 hold after pulse", {1'b0, rsp_code}, {1'b0, EX});

    finish_run();
  end

endmodule